// File: doc/BRIEF.md
# Parametric Floating-Point Multiplier

This block multiplies two binary floating-point numbers in a packed sign, exponent and fraction format. The exponent width and the fraction width are parameters. The product and three exception flags come out through combinational logic, with no clock and no handshake. Each operand is first sorted into zero, subnormal, normal, infinity, quiet NaN or signalling NaN. A subnormal operand has its significand shifted up so that its leading one sits at the hidden-bit position. The exponent it carries is lowered to match.

The two full significands are multiplied at full width and the product is brought back into range. Every bit below the guard position is gathered into a sticky bit. A build-time parameter chooses the final rounding: round to nearest with ties to even, or plain truncation. A product whose exponent falls below the normal range is shifted right to become a subnormal or zero. A product whose exponent goes past the largest finite value becomes infinity. The defaults, 8 exponent bits and 23 fraction bits, give the common single-precision layout, and all example values below use that layout.

Top module: `fpm_mul`

## Requirements
- R1: For every result that is not a NaN, the sign bit (bit W-1) equals the XOR of the two operand sign bits. This includes zero and infinity results.
- R2: The product of two normal operands is the correctly rounded product. Examples: 0x3FC00000 × 0x3FC00000 = 0x40100000 and 0xC0000000 × 0x40400000 = 0xC0C00000.
- R3: With ROUND_NEAREST = 0, the bits below the kept fraction are dropped. Example: 0x3F800001 × 0x3FE00000 gives 0x3FE00001 in this mode, against 0x3FE00002 when rounding to nearest.
- R4: With ROUND_NEAREST = 1, an exact halfway case rounds to the even fraction. Example: 0x3F800001 × 0x3FC00000 gives 0x3FC00002, and 0x3F800003 × 0x3FC00000 gives 0x3FC00004.
- R5: A subnormal operand (exponent field 0, fraction nonzero) is normalised before the multiply. Example: 0x00000001 × 0x4B000000 = 0x00800000, with no flags.
- R6: A finite product whose rounded biased exponent reaches all ones becomes infinity (exponent all ones, fraction 0) and raises overflow. The largest finite value times 1.0 is returned unchanged without overflow.
- R7: A finite nonzero product whose biased exponent before rounding is below 1 is shifted right into a subnormal or zero and raises underflow. Example: 0x00800000 × 0x3F000000 = 0x00400000. Example: 0x00000003 × 0x3F000000 = 0x00000002 when rounding to nearest and 0x00000001 when truncating.
- R8: Zero times infinity, in either order, returns the quiet NaN 0x7FC00000 (sign 0, exponent all ones, fraction MSB 1, other bits 0) and raises invalid.
- R9: If either operand is a NaN, the result is the quiet NaN. Invalid is raised only when a NaN operand is signalling (fraction MSB 0).
- R10: Infinity times a finite nonzero value, or infinity times infinity, gives a signed infinity with no flags. Zero times a finite value gives a signed zero with no flags.
- R11: Overflow and underflow are never raised together, and neither is raised on a NaN, infinity or zero result that comes from a special operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | EXP_W+MAN_W+1 | First operand, packed {sign, exponent, fraction} |
| b | input | EXP_W+MAN_W+1 | Second operand, same layout |
| prod | output | EXP_W+MAN_W+1 | Rounded product, same layout |
| underflow | output | 1 | Product was tiny before rounding and became subnormal or zero |
| overflow | output | 1 | Product went past the largest finite value and became infinity |
| invalid | output | 1 | Zero times infinity, or a signalling NaN operand |

## Verification
The block has no registers, so every result and flag belongs to the same cycle as the operands that produce it. The bench drives each operand pair on a falling clock edge. It reads the product and flags a few nanoseconds later, once the combinational logic has settled and well before the next rising edge. New operands are applied on the next falling edge. Two copies of the block, one rounding to nearest and one truncating, see the same operands, so each rounding case is compared in both modes on the same vector.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  // Operand classes found by the unpack stage
  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_NORM = 3'd1,
    CL_SUB  = 3'd2,
    CL_INF  = 3'd3,
    CL_QNAN = 3'd4,
    CL_SNAN = 3'd5
  } fp_class_e;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int XW    = EXP_W + 3
) (
  input  logic [EXP_W+MAN_W:0]  op,
  output logic                  sign,
  output fp_class_e             cls,
  output logic signed [XW-1:0]  exp_eff,
  output logic [MAN_W:0]        sig
);
  localparam int LZW = $clog2(MAN_W + 1);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] frac;
  logic [LZW-1:0]   lz;
  logic             found;

  assign sign  = op[EXP_W+MAN_W];
  assign exp_f = op[EXP_W+MAN_W-1:MAN_W];
  assign frac  = op[MAN_W-1:0];

  // leading-zero count of the fraction, used only for subnormals
  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = MAN_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (frac[i]) found = 1'b1;
        else         lz    = lz + 1'b1;
      end
    end
  end

  always_comb begin
    if (exp_f == '0)
      cls = (frac == '0) ? CL_ZERO : CL_SUB;
    else if (exp_f == '1)
      cls = (frac == '0) ? CL_INF : (frac[MAN_W-1] ? CL_QNAN : CL_SNAN);
    else
      cls = CL_NORM;
  end

  always_comb begin
    case (cls)
      CL_NORM: begin
        sig     = {1'b1, frac};
        exp_eff = XW'(exp_f);
      end
      CL_SUB: begin
        sig     = {1'b0, frac} << (lz + 1'b1);
        exp_eff = XW'(0) - XW'(lz);
      end
      default: begin
        sig     = {1'b0, frac};
        exp_eff = '0;
      end
    endcase
  end
endmodule

// File: rtl/fpm_round.sv
module fpm_round #(
  parameter int EXP_W         = 8,
  parameter int MAN_W         = 23,
  parameter int XW            = EXP_W + 3,
  parameter bit ROUND_NEAREST = 1'b1
) (
  input  logic [2*MAN_W+1:0]   norm,     // leading one at the top bit
  input  logic signed [XW-1:0] exp_pre,  // biased exponent before rounding
  output logic [EXP_W-1:0]     exp_field,
  output logic [MAN_W-1:0]     frac,
  output logic                 ovf,
  output logic                 unf
);
  localparam int PW   = 2 * MAN_W + 2;
  localparam int SHW  = $clog2(PW + 1);
  localparam int MAXE = (1 << EXP_W) - 1;

  logic                 tiny;
  logic signed [XW-1:0] sh_full;
  logic [SHW-1:0]       sh;
  logic [PW-1:0]        shifted;
  logic                 lost;
  logic [MAN_W:0]       kept;
  logic                 guard;
  logic                 sticky;
  logic                 inc;
  logic [MAN_W+1:0]     rounded;
  logic signed [XW-1:0] exp_fin;

  assign tiny    = $signed(exp_pre) < $signed(XW'(1));
  assign sh_full = XW'(1) - exp_pre;

  always_comb begin
    if (!tiny)                    sh = '0;
    else if (sh_full > XW'(PW))   sh = SHW'(PW);
    else                          sh = SHW'(sh_full);
  end

  assign shifted = norm >> sh;
  assign lost    = |(norm & ~({PW{1'b1}} << sh));
  assign kept    = shifted[PW-1:MAN_W+1];
  assign guard   = shifted[MAN_W];
  assign sticky  = (|shifted[MAN_W-1:0]) | lost;

  generate
    if (ROUND_NEAREST) begin : g_rne
      assign inc = guard & (sticky | kept[0]);
    end else begin : g_chop
      assign inc = 1'b0;
    end
  endgenerate

  assign rounded = {1'b0, kept} + (MAN_W+2)'(inc);

  always_comb begin
    if (tiny) begin
      exp_fin = rounded[MAN_W] ? XW'(1) : XW'(0);
      frac    = rounded[MAN_W-1:0];
    end else if (rounded[MAN_W+1]) begin
      exp_fin = exp_pre + XW'(1);
      frac    = rounded[MAN_W:1];
    end else begin
      exp_fin = exp_pre;
      frac    = rounded[MAN_W-1:0];
    end
    ovf = !tiny && ($signed(exp_fin) >= $signed(XW'(MAXE)));
    unf = tiny;
    if (ovf) begin
      exp_field = '1;
      frac      = '0;
    end else begin
      exp_field = exp_fin[EXP_W-1:0];
    end
  end

  always_comb begin
    if (unf) AST_UNF_LOW_EXP: assert (exp_field <= EXP_W'(1)); // R7
  end
endmodule

// File: rtl/fpm_mul.sv
module fpm_mul
  import fpm_pkg::*;
#(
  parameter int EXP_W         = 8,
  parameter int MAN_W         = 23,
  parameter bit ROUND_NEAREST = 1'b1
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  output logic [EXP_W+MAN_W:0] prod,
  output logic                 underflow,
  output logic                 overflow,
  output logic                 invalid
);
  localparam int W    = EXP_W + MAN_W + 1;
  localparam int XW   = EXP_W + 3;
  localparam int PW   = 2 * MAN_W + 2;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic                 sa, sb, sr;
  fp_class_e            ca, cb;
  logic signed [XW-1:0] ea, eb, exp_pre;
  logic [MAN_W:0]       siga, sigb;
  logic [PW-1:0]        prod_sig, norm;
  logic                 carry;
  logic [EXP_W-1:0]     r_exp;
  logic [MAN_W-1:0]     r_frac;
  logic                 r_ovf, r_unf;
  logic                 nan_any, snan_any, inf_a, inf_b, zero_a, zero_b;

  fpm_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .XW(XW)) u_unp_a (
    .op(a), .sign(sa), .cls(ca), .exp_eff(ea), .sig(siga));
  fpm_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .XW(XW)) u_unp_b (
    .op(b), .sign(sb), .cls(cb), .exp_eff(eb), .sig(sigb));

  assign sr       = sa ^ sb;
  assign prod_sig = PW'(siga) * PW'(sigb);
  assign carry    = prod_sig[PW-1];
  assign norm     = carry ? prod_sig : (prod_sig << 1);
  assign exp_pre  = ea + eb - XW'(BIAS) + XW'(carry);

  fpm_round #(.EXP_W(EXP_W), .MAN_W(MAN_W), .XW(XW), .ROUND_NEAREST(ROUND_NEAREST)) u_round (
    .norm(norm), .exp_pre(exp_pre), .exp_field(r_exp), .frac(r_frac),
    .ovf(r_ovf), .unf(r_unf));

  assign snan_any = (ca == CL_SNAN) || (cb == CL_SNAN);
  assign nan_any  = snan_any || (ca == CL_QNAN) || (cb == CL_QNAN);
  assign inf_a    = (ca == CL_INF);
  assign inf_b    = (cb == CL_INF);
  assign zero_a   = (ca == CL_ZERO);
  assign zero_b   = (cb == CL_ZERO);

  // special operands override the arithmetic path
  always_comb begin
    prod      = {sr, r_exp, r_frac};
    overflow  = r_ovf;
    underflow = r_unf;
    invalid   = 1'b0;
    if (nan_any) begin
      prod      = QNAN;
      overflow  = 1'b0;
      underflow = 1'b0;
      invalid   = snan_any;
    end else if ((inf_a && zero_b) || (zero_a && inf_b)) begin
      prod      = QNAN;
      overflow  = 1'b0;
      underflow = 1'b0;
      invalid   = 1'b1;
    end else if (inf_a || inf_b) begin
      prod      = {sr, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      overflow  = 1'b0;
      underflow = 1'b0;
    end else if (zero_a || zero_b) begin
      prod      = {sr, {(W-1){1'b0}}};
      overflow  = 1'b0;
      underflow = 1'b0;
    end
  end

  always_comb begin
    AST_FLAGS_EXCLUSIVE: assert (!(overflow && underflow)); // R11
    if (invalid) AST_INVALID_QNAN: assert (prod == QNAN); // R8
    if (overflow) AST_OVF_IS_INF: assert (prod[W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}}); // R6
    if (prod[W-2:MAN_W] != '1 || prod[MAN_W-1:0] == '0)
      AST_SIGN_XOR: assert (prod[W-1] == (a[W-1] ^ b[W-1])); // R1
  end
endmodule

// File: tb/fpm_mul_test.sv
module fpm_mul_test;
  logic        clk;
  logic [31:0] a, b;
  logic [31:0] p_n, p_t;
  logic        unf_n, ovf_n, inv_n, unf_t, ovf_t, inv_t;
  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  fpm_mul #(.EXP_W(8), .MAN_W(23), .ROUND_NEAREST(1'b1)) uut (
    .a(a), .b(b), .prod(p_n), .underflow(unf_n), .overflow(ovf_n), .invalid(inv_n));
  fpm_mul #(.EXP_W(8), .MAN_W(23), .ROUND_NEAREST(1'b0)) uut_chop (
    .a(a), .b(b), .prod(p_t), .underflow(unf_t), .overflow(ovf_t), .invalid(inv_t));

  // flags packed as {underflow, overflow, invalid}
  task automatic run_vec(input string req, input logic [31:0] va, input logic [31:0] vb,
                         input logic [31:0] exp_n, input logic [31:0] exp_t, input logic [2:0] fl);
    @(negedge clk);
    a = va;
    b = vb;
    #2;
    n_run++;
    if (p_n !== exp_n || {unf_n, ovf_n, inv_n} !== fl) begin
      n_fail++;
      $display("FAIL %s nearest %h*%h: got %h flags %b, expected %h flags %b",
               req, va, vb, p_n, {unf_n, ovf_n, inv_n}, exp_n, fl);
    end
    n_run++;
    if (p_t !== exp_t || {unf_t, ovf_t, inv_t} !== fl) begin
      n_fail++;
      $display("FAIL %s chop %h*%h: got %h flags %b, expected %h flags %b",
               req, va, vb, p_t, {unf_t, ovf_t, inv_t}, exp_t, fl);
    end
  endtask

  task automatic t_idle_state;
    run_vec("R10", 32'h0, 32'h0, 32'h0, 32'h0, 3'b000);
  endtask

  task automatic t_normal;
    run_vec("R2", 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000, 3'b000);
    run_vec("R2", 32'h3FC00000, 32'h40000000, 32'h40400000, 32'h40400000, 3'b000);
    run_vec("R2", 32'h3FC00000, 32'h3FC00000, 32'h40100000, 32'h40100000, 3'b000);
    run_vec("R1", 32'hC0000000, 32'h40400000, 32'hC0C00000, 32'hC0C00000, 3'b000);
    run_vec("R1", 32'hC0000000, 32'hC0400000, 32'h40C00000, 32'h40C00000, 3'b000);
  endtask

  task automatic t_rounding;
    run_vec("R3", 32'h3F800001, 32'h3FE00000, 32'h3FE00002, 32'h3FE00001, 3'b000);
    run_vec("R4", 32'h3F800001, 32'h3FC00000, 32'h3FC00002, 32'h3FC00001, 3'b000);
    run_vec("R4", 32'h3F800003, 32'h3FC00000, 32'h3FC00004, 32'h3FC00004, 3'b000);
    run_vec("R3", 32'h3F800001, 32'h3F800001, 32'h3F800002, 32'h3F800002, 3'b000);
  endtask

  task automatic t_subnormal;
    run_vec("R5", 32'h00000001, 32'h4B000000, 32'h00800000, 32'h00800000, 3'b000);
    run_vec("R5", 32'h4B000000, 32'h80000001, 32'h80800000, 32'h80800000, 3'b000);
  endtask

  task automatic t_overflow;
    run_vec("R6", 32'h7F000000, 32'h40000000, 32'h7F800000, 32'h7F800000, 3'b010);
    run_vec("R6", 32'hFF000000, 32'h40000000, 32'hFF800000, 32'hFF800000, 3'b010);
    run_vec("R6", 32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 32'h7F7FFFFF, 3'b000);
  endtask

  task automatic t_underflow;
    run_vec("R7", 32'h00800000, 32'h3F000000, 32'h00400000, 32'h00400000, 3'b100);
    run_vec("R7", 32'h00000003, 32'h3F000000, 32'h00000002, 32'h00000001, 3'b100);
    run_vec("R7", 32'h00800000, 32'h00800000, 32'h00000000, 32'h00000000, 3'b100);
    run_vec("R7", 32'h80800000, 32'h00800000, 32'h80000000, 32'h80000000, 3'b100);
  endtask

  task automatic t_invalid;
    run_vec("R8", 32'h00000000, 32'h7F800000, 32'h7FC00000, 32'h7FC00000, 3'b001);
    run_vec("R8", 32'hFF800000, 32'h80000000, 32'h7FC00000, 32'h7FC00000, 3'b001);
  endtask

  task automatic t_nan;
    run_vec("R9", 32'h7FC00001, 32'h3F800000, 32'h7FC00000, 32'h7FC00000, 3'b000);
    run_vec("R9", 32'h7F800001, 32'h3F800000, 32'h7FC00000, 32'h7FC00000, 3'b001);
    run_vec("R9", 32'h00000000, 32'hFF800005, 32'h7FC00000, 32'h7FC00000, 3'b001);
  endtask

  task automatic t_special;
    run_vec("R10", 32'h7F800000, 32'hBF800000, 32'hFF800000, 32'hFF800000, 3'b000);
    run_vec("R10", 32'hFF800000, 32'hFF800000, 32'h7F800000, 32'h7F800000, 3'b000);
    run_vec("R10", 32'h80000000, 32'h3F800000, 32'h80000000, 32'h80000000, 3'b000);
    run_vec("R11", 32'h00000001, 32'h7F800000, 32'h7F800000, 32'h7F800000, 3'b000);
  endtask

  initial begin
    a = '0;
    b = '0;
    t_idle_state();
    t_normal();
    t_rounding();
    t_subnormal();
    t_overflow();
    t_underflow();
    t_invalid();
    t_nan();
    t_special();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got running, expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule